// File: doc/BRIEF.md
# ECC Background Scrub Engine

The engine walks a protected memory in the background, one location at a time. For each location it issues a read and receives 64 data bits and an 8-bit check field. It then decodes the word with a single-error-correcting, double-error-detecting code. When a single flipped bit is found, in the data or in the check field, the engine writes the repaired data and a freshly generated check field back to the same location. Corrected words are rewritten during each pass, so isolated upsets cannot build up into words that the code can no longer repair.

A word with two flipped bits is never rewritten. The engine counts it and records its address, so that system software or a higher-level policy can act on it. The engine has a plain synchronous memory port with one grant input for arbitration against functional traffic. A programmable rest period is inserted between visits. After the last location the address wraps to zero and the sweep begins again.

Top module: `scrub_engine`

## Requirements
- R1: The check field is computed from the data as follows. Data bit i occupies the i-th position in ascending order among positions 1..71 that are not powers of two. Check bit k (k = 0..6) is the XOR of every data bit whose position has bit k set. Check bit 7 is the XOR of all 64 data bits and check bits 0..6. Every write-back carries a check field built this way from its data.
- R2: Reads visit addresses 0, 1, ..., DEPTH-1 in order, then wrap to 0, and this repeats without end.
- R3: A word that decodes clean causes no write.
- R4: A word with exactly one flipped data bit is rewritten at the same address with that bit restored and a regenerated check field. The write request follows the read of that address, and the corrected counter increases by one.
- R5: A word with exactly one flipped check bit (any of bits 0..7) is rewritten with its data unchanged and a regenerated check field, and it counts as corrected.
- R6: A word with two flipped bits is not written. It increments the uncorrectable counter, and its address is latched on `err_addr` until a later uncorrectable word replaces it.
- R7: While `mem_gnt` is low, a pending request stays asserted with unchanged address, direction and data, and it is never withdrawn.
- R8: The memory returns read data one cycle after a read is accepted, and grant is held high. Under these conditions two reads in a row of clean words are accepted `gap_cycles`+4 cycles apart.
- R9: Both event counters saturate at 2^CNT_W-1 and never wrap.
- R10: After reset the counters and `err_addr` are zero, no request is driven during reset, and the first read targets address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gap_cycles | input | GAP_W | Rest setting between visits, sampled when a visit completes |
| mem_gnt | input | 1 | Arbiter grant; a request is accepted on a rising edge when both are high |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data word |
| mem_rchk | input | CHK_W | Read check field |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | clog2(DEPTH) | Request address |
| mem_wdata | output | DATA_W | Write data |
| mem_wchk | output | CHK_W | Write check field |
| corr_count | output | CNT_W | Saturating count of corrected words |
| uncorr_count | output | CNT_W | Saturating count of uncorrectable words |
| err_addr | output | clog2(DEPTH) | Address of the latest uncorrectable word |

## Verification
The test counts cycles from the edge where a read is accepted (cycle t). Read data arrives in t+1 and is decoded in t+2. A write request for a correctable word appears in t+3, the counters and `err_addr` change at the end of t+2, and the next read request appears in t+3+gap_cycles+1. A scoreboard compares every accepted handshake, sampled on the falling edge, against a queue of expected reads and writes, so a missing write, an extra write or a skipped address shows up on the handshake where it happens. Counter values are sampled three falling edges after the last read of a sweep is accepted, when the final decode has settled. Read spacing is measured only in sweeps where grant is held high.

// File: rtl/scrub_pkg.sv
`timescale 1ns/1ps
package scrub_pkg;
   localparam int DW   = 64;
   localparam int CW   = 8;
   localparam int HW   = CW - 1;
   localparam int NPOS = DW + HW;

   typedef enum logic [1:0] {VIS_CLEAN, VIS_FIXED, VIS_FATAL} verdict_e;

   // position of a data bit inside the Hamming codeword
   function automatic logic [HW-1:0] bit_pos(input int idx);
      int n;
      logic [HW-1:0] r;
      n = 0;
      r = '0;
      for (int p = 1; p <= NPOS; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (n == idx) r = HW'(p);
            n++;
         end
      end
      return r;
   endfunction

   function automatic logic [CW-1:0] gen_check(input logic [DW-1:0] d);
      logic [CW-1:0] c;
      logic [HW-1:0] pp;
      c = '0;
      for (int i = 0; i < DW; i++) begin
         pp = bit_pos(i);
         for (int k = 0; k < HW; k++)
            if (pp[k]) c[k] = c[k] ^ d[i];
      end
      c[CW-1] = (^d) ^ (^c[HW-1:0]);
      return c;
   endfunction
endpackage

// File: rtl/scrub_secded_check.sv
`timescale 1ns/1ps
module scrub_secded_check
   import scrub_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int CHK_W  = 8
) (
   input  logic [DATA_W-1:0] rd_data,
   input  logic [CHK_W-1:0]  rd_chk,
   output logic [DATA_W-1:0] fix_data,
   output logic [CHK_W-1:0]  fix_chk,
   output verdict_e          verdict
);
   localparam int SW = CHK_W - 1;

   logic [CHK_W-1:0] recomputed;
   logic [SW-1:0]    syn;
   logic             odd;
   logic             hit;

   always_comb begin
      recomputed = gen_check(rd_data);
      syn        = recomputed[SW-1:0] ^ rd_chk[SW-1:0];
      odd        = (^rd_data) ^ (^rd_chk);
      fix_data   = rd_data;
      hit        = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (bit_pos(i) == syn) begin
            fix_data[i] = ~rd_data[i];
            hit         = 1'b1;
         end
      end
      if (!odd && syn == '0)
         verdict = VIS_CLEAN;
      else if (!odd)
         verdict = VIS_FATAL;
      else if (syn == '0 || $countones(syn) == 1 || hit)
         verdict = VIS_FIXED;
      else
         verdict = VIS_FATAL;
      fix_chk = gen_check(fix_data);
   end
endmodule

// File: rtl/scrub_walker.sv
`timescale 1ns/1ps
module scrub_walker
   import scrub_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int AW     = 3,
   parameter int GW     = 8,
   parameter int DATA_W = 64,
   parameter int CHK_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [GW-1:0]     gap_cycles,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [CHK_W-1:0]  mem_rchk,
   input  verdict_e          verdict,
   input  logic [DATA_W-1:0] fix_data,
   input  logic [CHK_W-1:0]  fix_chk,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [CHK_W-1:0]  mem_wchk,
   output logic [DATA_W-1:0] cap_data,
   output logic [CHK_W-1:0]  cap_chk,
   output logic              evt_fix,
   output logic              evt_fatal,
   output logic [AW-1:0]     evt_addr
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   typedef enum logic [2:0] {W_GAP, W_RD, W_RWAIT, W_EVAL, W_WR} wstate_e;

   wstate_e           state;
   logic [AW-1:0]     cur;
   logic [GW-1:0]     rest;
   logic [DATA_W-1:0] wd;
   logic [CHK_W-1:0]  wc;
   logic              advance;

   assign advance = (state == W_EVAL && verdict != VIS_FIXED) ||
                    (state == W_WR && mem_gnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= W_GAP;
         cur      <= '0;
         rest     <= '0;
         cap_data <= '0;
         cap_chk  <= '0;
         wd       <= '0;
         wc       <= '0;
      end else begin
         case (state)
            W_GAP:   if (rest == '0) state <= W_RD;
                     else rest <= rest - 1'b1;
            W_RD:    if (mem_gnt) state <= W_RWAIT;
            W_RWAIT: if (mem_rvalid) begin
                        cap_data <= mem_rdata;
                        cap_chk  <= mem_rchk;
                        state    <= W_EVAL;
                     end
            W_EVAL:  if (verdict == VIS_FIXED) begin
                        wd    <= fix_data;
                        wc    <= fix_chk;
                        state <= W_WR;
                     end
            default: ;
         endcase
         if (advance) begin
            cur   <= (cur == LAST) ? '0 : cur + 1'b1;
            rest  <= gap_cycles;
            state <= W_GAP;
         end
      end
   end

   assign mem_req   = (state == W_RD) || (state == W_WR);
   assign mem_we    = (state == W_WR);
   assign mem_addr  = cur;
   assign mem_wdata = wd;
   assign mem_wchk  = wc;
   assign evt_fix   = (state == W_EVAL) && (verdict == VIS_FIXED);
   assign evt_fatal = (state == W_EVAL) && (verdict == VIS_FATAL);
   assign evt_addr  = cur;
endmodule

// File: rtl/scrub_tally.sv
`timescale 1ns/1ps
module scrub_tally #(
   parameter int AW = 3,
   parameter int NW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          evt_fix,
   input  logic          evt_fatal,
   input  logic [AW-1:0] evt_addr,
   output logic [NW-1:0] corr_count,
   output logic [NW-1:0] uncorr_count,
   output logic [AW-1:0] err_addr
);
   localparam logic [NW-1:0] TOP = '1;

   logic [1:0]          hit;
   logic [1:0][NW-1:0]  cnt_all;

   assign hit = {evt_fatal, evt_fix};

   for (genvar g = 0; g < 2; g++) begin : g_cnt
      logic [NW-1:0] val;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   val <= '0;
         else if (hit[g] && val != TOP) val <= val + 1'b1;
      end
      assign cnt_all[g] = val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         err_addr <= '0;
      else if (evt_fatal) err_addr <= evt_addr;
   end

   assign corr_count   = cnt_all[0];
   assign uncorr_count = cnt_all[1];
endmodule

// File: rtl/scrub_engine.sv
`timescale 1ns/1ps
module scrub_engine
   import scrub_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 64,
   parameter int CHK_W  = 8,
   parameter int GAP_W  = 8,
   parameter int CNT_W  = 16,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [GAP_W-1:0]  gap_cycles,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [CHK_W-1:0]  mem_rchk,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [CHK_W-1:0]  mem_wchk,
   output logic [CNT_W-1:0]  corr_count,
   output logic [CNT_W-1:0]  uncorr_count,
   output logic [AW-1:0]     err_addr
);
   if (DATA_W != DW) begin : g_bad_data
      $error("scrub_engine: DATA_W must equal the package code width");
   end
   if (CHK_W != CW) begin : g_bad_chk
      $error("scrub_engine: CHK_W must equal the package check width");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("scrub_engine: DEPTH must be at least 2");
   end
   if (GAP_W < 1 || CNT_W < 1) begin : g_bad_width
      $error("scrub_engine: GAP_W and CNT_W must be positive");
   end

   logic [DATA_W-1:0] cap_data, fix_data;
   logic [CHK_W-1:0]  cap_chk, fix_chk;
   verdict_e          verdict;
   logic              evt_fix, evt_fatal;
   logic [AW-1:0]     evt_addr;

   scrub_secded_check #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_check (
      .rd_data (cap_data),
      .rd_chk  (cap_chk),
      .fix_data(fix_data),
      .fix_chk (fix_chk),
      .verdict (verdict)
   );

   scrub_walker #(
      .DEPTH(DEPTH), .AW(AW), .GW(GAP_W), .DATA_W(DATA_W), .CHK_W(CHK_W)
   ) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .gap_cycles(gap_cycles),
      .mem_gnt   (mem_gnt),
      .mem_rvalid(mem_rvalid),
      .mem_rdata (mem_rdata),
      .mem_rchk  (mem_rchk),
      .verdict   (verdict),
      .fix_data  (fix_data),
      .fix_chk   (fix_chk),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_wchk  (mem_wchk),
      .cap_data  (cap_data),
      .cap_chk   (cap_chk),
      .evt_fix   (evt_fix),
      .evt_fatal (evt_fatal),
      .evt_addr  (evt_addr)
   );

   scrub_tally #(.AW(AW), .NW(CNT_W)) u_tally (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_fix     (evt_fix),
      .evt_fatal   (evt_fatal),
      .evt_addr    (evt_addr),
      .corr_count  (corr_count),
      .uncorr_count(uncorr_count),
      .err_addr    (err_addr)
   );
endmodule

// File: rtl/scrub_engine_props.sv
`timescale 1ns/1ps
module scrub_engine_props
   import scrub_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int AW     = 3,
   parameter int DATA_W = 64,
   parameter int CHK_W  = 8,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_gnt,
   input logic [AW-1:0]     mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [CHK_W-1:0]  mem_wchk,
   input logic [CNT_W-1:0]  corr_count,
   input logic [CNT_W-1:0]  uncorr_count
);
   logic          seen_rd;
   logic          last_was_rd;
   logic [AW-1:0] last_addr;
   logic [AW-1:0] last_rd_addr;
   logic [AW-1:0] exp_next;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_rd      <= 1'b0;
         last_was_rd  <= 1'b0;
         last_addr    <= '0;
         last_rd_addr <= '0;
      end else if (mem_req && mem_gnt) begin
         last_was_rd <= !mem_we;
         last_addr   <= mem_addr;
         if (!mem_we) begin
            seen_rd      <= 1'b1;
            last_rd_addr <= mem_addr;
         end
      end
   end

   assign exp_next = (last_rd_addr == AW'(DEPTH - 1)) ? '0 : last_rd_addr + 1'b1;

   a_r7_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   a_r2_sweep_order: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && seen_rd) |-> (mem_addr == exp_next));

   a_r10_first_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && !seen_rd) |-> (mem_addr == '0));

   a_r4_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (last_was_rd && last_addr == mem_addr));

   a_r1_write_check_field: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_wchk == gen_check(mem_wdata)));

   a_r9_corr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (corr_count != $past(corr_count)) |-> (corr_count == $past(corr_count) + 1'b1));

   a_r6_uncorr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (uncorr_count != $past(uncorr_count)) |-> (uncorr_count == $past(uncorr_count) + 1'b1));
endmodule

bind scrub_engine scrub_engine_props #(
   .DEPTH(DEPTH), .AW(AW), .DATA_W(DATA_W), .CHK_W(CHK_W), .CNT_W(CNT_W)
) u_props (
   .clk         (clk),
   .rst_n       (rst_n),
   .mem_req     (mem_req),
   .mem_we      (mem_we),
   .mem_gnt     (mem_gnt),
   .mem_addr    (mem_addr),
   .mem_wdata   (mem_wdata),
   .mem_wchk    (mem_wchk),
   .corr_count  (corr_count),
   .uncorr_count(uncorr_count)
);

// File: tb/scrub_engine_test.sv
`timescale 1ns/1ps
module scrub_engine_test;
   localparam int DEPTH = 8;
   localparam int AW    = 3;
   localparam int CNTW  = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [7:0]        gap_cycles = 8'd3;
   logic              mem_gnt = 1'b1;
   logic              mem_rvalid;
   logic [63:0]       mem_rdata;
   logic [7:0]        mem_rchk;
   logic              mem_req, mem_we;
   logic [AW-1:0]     mem_addr;
   logic [63:0]       mem_wdata;
   logic [7:0]        mem_wchk;
   logic [CNTW-1:0]   corr_count, uncorr_count;
   logic [AW-1:0]     err_addr;

   always #4 clk = ~clk;

   scrub_engine #(.DEPTH(DEPTH), .GAP_W(8), .CNT_W(CNTW)) uut (
      .clk(clk), .rst_n(rst_n), .gap_cycles(gap_cycles), .mem_gnt(mem_gnt),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rchk(mem_rchk),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_wchk(mem_wchk), .corr_count(corr_count),
      .uncorr_count(uncorr_count), .err_addr(err_addr)
   );

   // memory model: read data one cycle after acceptance
   logic [71:0] mem [DEPTH];
   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (rst_n && mem_req && mem_gnt) begin
         if (mem_we) mem[mem_addr] <= {mem_wchk, mem_wdata};
         else begin
            mem_rvalid <= 1'b1;
            {mem_rchk, mem_rdata} <= mem[mem_addr];
         end
      end
   end

   typedef struct {
      bit          we;
      logic [2:0]  addr;
      logic [71:0] word;
      string       tag;
   } exp_t;
   exp_t sbq[$];

   int  n_chk = 0, n_fail = 0, cyc = 0, sweep = 1, last_rd = 0;
   bit  done = 0, stall = 1, ended = 0;
   logic [63:0] base [DEPTH];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [71:0] act, input logic [71:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // independent encoder built from R1
   function automatic logic [7:0] tb_chk(input logic [63:0] d);
      logic [7:0] c;
      int j;
      c = '0;
      j = 0;
      for (int p = 3; j < 64; p++) begin
         if ((p & (p - 1)) != 0) begin
            for (int k = 0; k < 7; k++) if (p[k]) c[k] = c[k] ^ d[j];
            j++;
         end
      end
      c[7] = ^{d, c[6:0]};
      return c;
   endfunction

   task automatic plant(input int a, input logic [71:0] flips, input string tag);
      exp_t e;
      mem[a] = {tb_chk(base[a]), base[a]} ^ flips;
      e.we = 0; e.addr = 3'(a); e.word = '0; e.tag = "R2";
      sbq.push_back(e);
      if ($countones(flips) == 1) begin
         e.we = 1; e.word = {tb_chk(base[a]), base[a]}; e.tag = tag;
         sbq.push_back(e);
      end
   endtask

   task automatic push_sweep();
      exp_t e;
      for (int a = 0; a < DEPTH; a++) begin
         e.we = 0; e.addr = 3'(a); e.word = '0; e.tag = "R3";
         sbq.push_back(e);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   endtask

   // grant driver
   initial begin
      int g;
      g = 0;
      forever begin
         @(posedge clk);
         #1;
         mem_gnt = stall ? (g % 3 == 2) : 1'b1;
         g++;
      end
   end

   // monitor / scoreboard
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         cyc++;
         if (rst_n && !done && mem_req && mem_gnt) begin
            if (sbq.size() == 0) begin
               check(0, "R3", "unexpected handshake", {mem_we, mem_addr}, '0);
            end else begin
               e = sbq.pop_front();
               check(mem_we == e.we, e.tag, "direction", 72'(mem_we), 72'(e.we));
               check(mem_addr == e.addr, e.tag, "address", 72'(mem_addr), 72'(e.addr));
               if (mem_we)
                  check({mem_wchk, mem_wdata} == e.word, e.tag, "write word",
                        {mem_wchk, mem_wdata}, e.word);
            end
            if (!mem_we) begin
               if (mem_addr == 3'd1 && sweep == 2)
                  check(cyc - last_rd == 7, "R8", "read spacing gap 3", 72'(cyc - last_rd), 72'd7);
               if (mem_addr == 3'd1 && sweep == 3)
                  check(cyc - last_rd == 4, "R8", "read spacing gap 0", 72'(cyc - last_rd), 72'd4);
               if (mem_addr == 3'd5)
                  check(err_addr == 3'd3, "R6", "err_addr mid sweep", 72'(err_addr), 72'd3);
               if (mem_addr == 3'd1 && sweep >= 2)
                  check(err_addr == 3'd7, "R6", "err_addr after wrap", 72'(err_addr), 72'd7);
               last_rd = cyc;
            end
         end
      end
   end

   // watchdog
   initial begin
      #(8 * 20000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   // driver
   initial begin
      int exp_unc;
      base[0] = 64'h0123_4567_89AB_CDEF;
      base[1] = 64'hFEDC_BA98_7654_3210;
      base[2] = 64'h0000_0000_0000_0000;
      base[3] = 64'hFFFF_FFFF_FFFF_FFFF;
      base[4] = 64'hA5A5_5A5A_C3C3_3C3C;
      base[5] = 64'h1357_9BDF_0246_8ACE;
      base[6] = 64'h8000_0000_0000_0001;
      base[7] = 64'h7777_0000_EEEE_1111;
      plant(0, 72'h0, "R3");                           // clean word
      plant(1, 72'(1) << 5, "R4");                     // data bit 5 flipped
      plant(2, 72'(1) << 67, "R5");                    // check bit 3 flipped
      plant(3, (72'(1) << 0) | (72'(1) << 63), "R6");  // two data bits
      plant(4, 72'(1) << 71, "R5");                    // overall check bit
      plant(5, 72'h0, "R3");
      plant(6, 72'(1) << 63, "R4");                    // top data bit
      plant(7, (72'(1) << 10) | (72'(1) << 66), "R6"); // data plus check bit
      repeat (3) @(negedge clk);
      // R10 reset state
      check(mem_req == 0, "R10", "req in reset", 72'(mem_req), 72'd0);
      check(corr_count == 0, "R10", "corr in reset", 72'(corr_count), 72'd0);
      check(uncorr_count == 0, "R10", "uncorr in reset", 72'(uncorr_count), 72'd0);
      check(err_addr == 0, "R10", "err_addr in reset", 72'(err_addr), 72'd0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      for (int k = 1; k <= 9; k++) begin
         do @(negedge clk); while (sbq.size() != 0);
         if (k < 9) begin
            sweep = k + 1;
            stall = 0;
            if (k + 1 == 3) gap_cycles = 8'd0;
            push_sweep();
         end else begin
            done = 1;
         end
         repeat (3) @(negedge clk);
         exp_unc = (2 * k > 15) ? 15 : 2 * k;
         check(corr_count == 4, "R4", "corrected count", 72'(corr_count), 72'd4);
         check(uncorr_count == CNTW'(exp_unc), "R9", "uncorrectable count",
               72'(uncorr_count), 72'(exp_unc));
         check(err_addr == 3'd7, "R6", "err_addr end of sweep", 72'(err_addr), 72'd7);
      end
      finish_run();
   end
endmodule